// File: doc/BRIEF.md
# Power-Controller Register Bank with Sticky Lock

This block is the byte-wide register store that a serial management slave reaches once it has decoded a transaction. Each access names an 8-bit command code. A write strobe carries one data byte into the selected register. The read port returns the selected register's value combinationally for the code currently presented. Registers follow per-code access rules: read/write, read-only, write-only, or read/write with some read-only bits inside. The bank also holds sticky status bits, which the power stage sets through single-cycle pulses.

Two mechanisms guard the control registers. The first is a write-protect register: while its bit 7 is set, writes to the operation and on/off configuration registers are dropped. The second is a lock register: writing a 1 to its bit 0 sets a lock that only the power-on reset clears. While the lock is set, writes to every code in the parameter mask `LOCK_MASK` are dropped. A write of any value to the clear-faults code wipes all status bits. A status pulse that arrives in the same cycle as the clear still sets its bit.

The inputs are plain control pins: a strobe, a code and a byte, with no back-pressure. A write takes effect at the rising clock edge where `wr_en` is high. Reads show the new value from that edge onward.

Top module: `pmreg_bank`

## Requirements
- R1: After power-on reset, code 0x01 reads 0x80, code 0x02 reads 0x17, code 0x10 reads 0x00, the lock code (default 0xD0) reads 0x00 and the status code (default 0x79) reads 0x00.
- R2: Code 0x01 (operation) is read/write: a permitted write of byte v makes it read v.
- R3: Code 0x02 (on/off configuration) keeps bits 4 and 0 at their reset value 1 under any write. Its other bits take the written value, so a permitted write of v reads back (v & 0xEE) | 0x11.
- R4: Code 0x19 always reads 0xB0 and code 0x20 always reads 0x22. Writes to them have no effect.
- R5: A write of any byte to code 0x03 clears every status bit at that edge. A read of code 0x03 returns 0x00.
- R6: A high `stat_set[i]` at an edge sets status bit i, which then stays set until a clear. The status code reads the bits in its low `NSTAT` positions. If a set and a clear arrive at the same edge, the set wins.
- R7: Writing the lock code with bit 0 = 1 sets the lock. A write with bit 0 = 0 does not set it. The lock code reads 0x01 while locked and 0x00 otherwise. Only `por_n` low clears the lock.
- R8: While locked, writes to codes whose bit is set in `LOCK_MASK` are ignored. By default these are 0x01, 0x02 and 0x10. Clear-faults still works.
- R9: While bit 7 of code 0x10 is set, writes to 0x01 and 0x02 are ignored. Code 0x10 itself stays writable, subject to the lock.
- R10: Codes that are not implemented read 0x00, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| cmd | input | 8 | Command code for both the write and the read |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Value of the register selected by `cmd` |
| stat_set | input | NSTAT | Status set pulses from the power stage |

## Verification
The bench looks first at the read-only bits inside the configuration register. A design that stored the full written byte would read back 0x00 or 0xEE where 0x11 or 0xFF is expected. It then raises a status pulse in the same cycle as a clear-faults write; with the priority reversed, that fault would be silently lost. It also checks that the lock stays set after a later write with bit 0 = 0, that locked codes ignore writes while clear-faults still works, and that only a power-on reset frees the bank. A lock that any write could clear would let the protected registers be rewritten.

// File: rtl/pmreg_pkg.sv
package pmreg_pkg;
  localparam logic [7:0] CODE_OPER  = 8'h01;
  localparam logic [7:0] CODE_ONOFF = 8'h02;
  localparam logic [7:0] CODE_CLRF  = 8'h03;
  localparam logic [7:0] CODE_WPROT = 8'h10;
  localparam logic [7:0] CODE_CAPAB = 8'h19;
  localparam logic [7:0] CODE_VMODE = 8'h20;

  localparam logic [7:0] OPER_RST  = 8'h80;
  localparam logic [7:0] ONOFF_RST = 8'h17;
  localparam logic [7:0] ONOFF_RO  = 8'h11;
  localparam logic [7:0] WPROT_RST = 8'h00;
  localparam logic [7:0] CAPAB_VAL = 8'hB0;
  localparam logic [7:0] VMODE_VAL = 8'h22;
  localparam int         WP_BIT    = 7;

  typedef struct packed {
    logic oper;
    logic onoff;
    logic wprot;
    logic lock;
    logic clrf;
  } wr_sel_t;
endpackage

// File: rtl/pmreg_lock.sv
module pmreg_lock (
  input  logic clk,
  input  logic por_n,
  input  logic set_req,
  output logic locked
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)       locked <= 1'b0;
    else if (set_req) locked <= 1'b1;
  end
endmodule

// File: rtl/pmreg_status.sv
module pmreg_status #(
  parameter int NSTAT = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic [NSTAT-1:0] set_i,
  input  logic             clr_i,
  output logic [NSTAT-1:0] stat_o
);
  for (genvar i = 0; i < NSTAT; i++) begin : g_bit
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)        stat_o[i] <= 1'b0;
      else if (set_i[i]) stat_o[i] <= 1'b1;
      else if (clr_i)    stat_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/pmreg_wgate.sv
module pmreg_wgate
  import pmreg_pkg::*;
#(
  parameter int          CW        = 8,
  parameter logic [CW-1:0] LOCK_CODE = 8'hD0,
  parameter logic [(1<<CW)-1:0] LOCK_MASK = '0
) (
  input  logic          wr_en,
  input  logic [CW-1:0] cmd,
  input  logic          locked,
  input  logic          wp_block,
  output wr_sel_t       sel
);
  logic lock_ok;
  assign lock_ok = !(locked && LOCK_MASK[cmd]);

  always_comb begin
    sel       = '0;
    sel.oper  = wr_en && lock_ok && !wp_block && (cmd == CW'(CODE_OPER));
    sel.onoff = wr_en && lock_ok && !wp_block && (cmd == CW'(CODE_ONOFF));
    sel.wprot = wr_en && lock_ok && (cmd == CW'(CODE_WPROT));
    sel.lock  = wr_en && lock_ok && (cmd == LOCK_CODE);
    sel.clrf  = wr_en && (cmd == CW'(CODE_CLRF));
  end
endmodule

// File: rtl/pmreg_bank.sv
module pmreg_bank
  import pmreg_pkg::*;
#(
  parameter int NSTAT = 8,
  parameter logic [7:0] LOCK_CODE = 8'hD0,
  parameter logic [7:0] STAT_CODE = 8'h79,
  parameter logic [255:0] LOCK_MASK =
    (256'd1 << 8'h01) | (256'd1 << 8'h02) | (256'd1 << 8'h10)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             wr_en,
  input  logic [7:0]       cmd,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  input  logic [NSTAT-1:0] stat_set
);
  localparam int CW = 8;

  wr_sel_t          sel;
  logic             locked;
  logic [7:0]       oper_q, onoff_q, wprot_q;
  logic [NSTAT-1:0] stat_q;
  logic [7:0]       stat_ext;

  pmreg_wgate #(.CW(CW), .LOCK_CODE(LOCK_CODE), .LOCK_MASK(LOCK_MASK)) u_gate (
    .wr_en(wr_en), .cmd(cmd), .locked(locked),
    .wp_block(wprot_q[WP_BIT]), .sel(sel)
  );

  pmreg_lock u_lock (
    .clk(clk), .por_n(por_n), .set_req(sel.lock && wr_data[0]), .locked(locked)
  );

  pmreg_status #(.NSTAT(NSTAT)) u_stat (
    .clk(clk), .por_n(por_n), .set_i(stat_set), .clr_i(sel.clrf), .stat_o(stat_q)
  );

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      oper_q  <= OPER_RST;
      onoff_q <= ONOFF_RST;
      wprot_q <= WPROT_RST;
    end else begin
      if (sel.oper)  oper_q  <= wr_data;
      if (sel.onoff) onoff_q <= (wr_data & ~ONOFF_RO) | (onoff_q & ONOFF_RO);
      if (sel.wprot) wprot_q <= wr_data;
    end
  end

  always_comb begin
    stat_ext = '0;
    stat_ext[NSTAT-1:0] = stat_q;
  end

  always_comb begin
    if      (cmd == CODE_OPER)  rd_data = oper_q;
    else if (cmd == CODE_ONOFF) rd_data = onoff_q;
    else if (cmd == CODE_WPROT) rd_data = wprot_q;
    else if (cmd == CODE_CAPAB) rd_data = CAPAB_VAL;
    else if (cmd == CODE_VMODE) rd_data = VMODE_VAL;
    else if (cmd == LOCK_CODE)  rd_data = {7'd0, locked};
    else if (cmd == STAT_CODE)  rd_data = stat_ext;
    else                        rd_data = 8'h00;
  end
endmodule

// File: rtl/pmreg_bank_chk.sv
module pmreg_bank_chk #(
  parameter int NSTAT = 8
) (
  input logic             clk,
  input logic             por_n,
  input logic             wr_en,
  input logic [7:0]       cmd,
  input logic [7:0]       rd_data,
  input logic [NSTAT-1:0] stat_set,
  input logic             locked,
  input logic [7:0]       oper_q,
  input logic [7:0]       onoff_q,
  input logic [NSTAT-1:0] stat_q
);
  // R4
  p_capab_fixed_r4: assert property (@(posedge clk) disable iff (!por_n)
    (cmd == 8'h19) |-> (rd_data == 8'hB0));
  // R7
  p_lock_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    locked |=> locked);
  // R8
  p_locked_oper_r8: assert property (@(posedge clk) disable iff (!por_n)
    (locked && wr_en && cmd == 8'h01) |=> $stable(oper_q));
  // R3
  p_onoff_ro_r3: assert property (@(posedge clk) disable iff (!por_n)
    1'b1 |=> ((onoff_q & 8'h11) == 8'h11));
  // R6
  p_set_wins_r6: assert property (@(posedge clk) disable iff (!por_n)
    (stat_set != '0) |=> ((stat_q & $past(stat_set)) == $past(stat_set)));
  // R6
  p_stat_hold_r6: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_en && cmd == 8'h03) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R5
  p_clrf_reads_zero_r5: assert property (@(posedge clk) disable iff (!por_n)
    (cmd == 8'h03) |-> (rd_data == 8'h00));
endmodule

bind pmreg_bank pmreg_bank_chk #(.NSTAT(NSTAT)) u_chk (
  .clk(clk), .por_n(por_n), .wr_en(wr_en), .cmd(cmd), .rd_data(rd_data),
  .stat_set(stat_set), .locked(locked), .oper_q(oper_q), .onoff_q(onoff_q),
  .stat_q(stat_q)
);

// File: tb/pmreg_bank_test.sv
module pmreg_bank_test;
  localparam int NSTAT = 8;
  localparam logic [7:0] LCK = 8'hD0;
  localparam logic [7:0] STC = 8'h79;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] cmd = 8'h00;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic [NSTAT-1:0] stat_set = '0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pmreg_bank #(.NSTAT(NSTAT)) uut (
    .clk(clk), .por_n(por_n), .wr_en(wr_en), .cmd(cmd),
    .wr_data(wr_data), .rd_data(rd_data), .stat_set(stat_set)
  );

  typedef struct packed {
    logic       we;
    logic [7:0] code;
    logic [7:0] data;
    logic [7:0] rcode;
    logic [7:0] exp;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{1'b0, 8'h00, 8'h00, 8'h01, 8'h80, 8'd1},   // R1 oper reset
    '{1'b0, 8'h00, 8'h00, 8'h02, 8'h17, 8'd1},   // R1 on/off reset
    '{1'b0, 8'h00, 8'h00, 8'h10, 8'h00, 8'd1},   // R1 write protect reset
    '{1'b0, 8'h00, 8'h00, 8'h19, 8'hB0, 8'd4},   // R4 capability
    '{1'b0, 8'h00, 8'h00, 8'h20, 8'h22, 8'd4},   // R4 voltage mode
    '{1'b1, 8'h01, 8'h40, 8'h01, 8'h40, 8'd2},   // R2 write/read
    '{1'b1, 8'h01, 8'h9A, 8'h01, 8'h9A, 8'd2},   // R2 second pattern
    '{1'b1, 8'h02, 8'hEE, 8'h02, 8'hFF, 8'd3},   // R3 ro bits stay 1
    '{1'b1, 8'h02, 8'h00, 8'h02, 8'h11, 8'd3},   // R3 clear writable bits
    '{1'b1, 8'h19, 8'h00, 8'h19, 8'hB0, 8'd4},   // R4 write ignored
    '{1'b1, 8'h20, 8'hFF, 8'h20, 8'h22, 8'd4},   // R4 write ignored
    '{1'b1, 8'h55, 8'hFF, 8'h55, 8'h00, 8'd10},  // R10 unimplemented reads 0
    '{1'b0, 8'h00, 8'h00, 8'h01, 8'h9A, 8'd10},  // R10 write left oper alone
    '{1'b0, 8'h00, 8'h00, 8'h03, 8'h00, 8'd5}    // R5 clear code reads 0
  };

  task automatic check(input logic [7:0] rc, input logic [7:0] exp, input string req);
    @(negedge clk);
    cmd = rc;
    #1;
    checks++;
    if (rd_data !== exp) begin
      fails++;
      $display("FAIL %s code %02h actual %02h expected %02h", req, rc, rd_data, exp);
    end
  endtask

  task automatic wr(input logic [7:0] c, input logic [7:0] d);
    @(negedge clk);
    cmd = c; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [NSTAT-1:0] s);
    @(negedge clk);
    stat_set = s;
    @(negedge clk);
    stat_set = '0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    check(LCK, 8'h00, "R1");
    check(STC, 8'h00, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VT[i].we) wr(VT[i].code, VT[i].data);
      check(VT[i].rcode, VT[i].exp, $sformatf("R%0d", VT[i].req));
    end

    // R6 sticky set, R5 clear
    pulse(8'h05);
    check(STC, 8'h05, "R6");
    pulse(8'h02);
    check(STC, 8'h07, "R6");
    wr(8'h03, 8'h5C);
    check(STC, 8'h00, "R5");
    // R6 set and clear at the same edge
    @(negedge clk);
    cmd = 8'h03; wr_data = 8'h00; wr_en = 1'b1; stat_set = 8'h80;
    @(negedge clk);
    wr_en = 1'b0; stat_set = '0;
    check(STC, 8'h80, "R6");

    // R9 write protect
    wr(8'h10, 8'h80);
    wr(8'h01, 8'h11);
    check(8'h01, 8'h9A, "R9");
    wr(8'h02, 8'hEE);
    check(8'h02, 8'h11, "R9");
    check(8'h10, 8'h80, "R9");
    wr(8'h10, 8'h00);
    wr(8'h01, 8'h11);
    check(8'h01, 8'h11, "R9");

    // R7 lock set rules
    wr(LCK, 8'hFE);
    check(LCK, 8'h00, "R7");
    wr(LCK, 8'h01);
    check(LCK, 8'h01, "R7");
    // R8 locked codes ignore writes
    wr(8'h01, 8'h22);
    check(8'h01, 8'h11, "R8");
    wr(8'h02, 8'hEE);
    check(8'h02, 8'h11, "R8");
    wr(8'h10, 8'h80);
    check(8'h10, 8'h00, "R8");
    pulse(8'h01);
    wr(8'h03, 8'hFF);
    check(STC, 8'h00, "R8");
    wr(LCK, 8'h00);
    check(LCK, 8'h01, "R7");

    // R7 only power-on reset frees the lock
    @(negedge clk);
    por_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    check(LCK, 8'h00, "R7");
    check(8'h01, 8'h80, "R1");
    wr(8'h01, 8'h33);
    check(8'h01, 8'h33, "R7");

    done = 1'b1;
    summary();
  end
endmodule